// File: doc/BRIEF.md
# SECDED Read Path with Demand Scrub

This block sits between a single request port and a word-wide memory array port. For each accepted write it extends the 64-bit data word with 8 check bits and stores all 72 bits. For each accepted read it recomputes the check bits from the returned data, forms a syndrome, and decides whether the word is clean, holds one flipped bit, or holds two flipped bits. A single flipped bit anywhere in the 72-bit word is repaired. The repaired data goes to the requester, and the repaired word is written back to the same address before the next request is taken. Two flipped bits are reported as uncorrectable and the raw data is passed through.

A control state machine with three states runs the block. `ST_IDLE` accepts requests. Transition `T_WRITE` stays in `ST_IDLE` and `T_ISSUE_READ` moves to `ST_RD_DATA`. `ST_RD_DATA` decodes the returned word. From there, `T_READ_DONE` returns to `ST_IDLE`, or `T_NEED_SCRUB` moves to `ST_SCRUB` when the word was correctable. `ST_SCRUB` writes back the re-encoded word and takes `T_SCRUB_DONE` to `ST_IDLE`. The request port is ready only in `ST_IDLE`. A bank of saturating counters, one per rank, tallies corrected reads. The rank is taken from the top address bits. One-cycle pulse outputs mark each correctable and each uncorrectable event and carry the failing address.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: An accepted write (req_valid, req_ready and req_write all high) drives mem_en=1, mem_we=1, mem_addr=req_addr in the same cycle. It also drives mem_wdata with the data in bits [63:0], check bits in [71:64], and even parity over all 72 bits.
- R2: A read accepted in cycle N drives a memory read in cycle N. The memory returns the word in cycle N+1. rsp_valid is high for exactly cycle N+2. On a clean word rsp_data equals the stored data and rsp_ce=rsp_ue=0.
- R3: If exactly one of the 72 stored bits is flipped, the response carries the originally written data with rsp_ce=1 and rsp_ue=0.
- R4: If exactly two of the 72 stored bits are flipped, the response carries rsp_ue=1 and rsp_ce=0, and rsp_data equals the stored bits [63:0] unchanged.
- R5: In the response cycle of a correctable read, the block writes the stored word back with its original 72-bit value to the same address (mem_en=1, mem_we=1), and req_ready is low in that cycle.
- R6: A read of an address after its scrub, with no new fault, reports rsp_ce=0 and rsp_ue=0 and returns the written data.
- R7: ce_pulse (correctable) or ue_pulse (uncorrectable) is high for the single response cycle, never both at once, with err_addr equal to the read address in that cycle.
- R8: Each rank (address bits [ADDR_W-1:ADDR_W-2] for 4 ranks) has a counter that starts at 0 after reset. It increments by one at the end of each correctable response of that rank and is unchanged by clean or uncorrectable reads. cnt_value shows the counter selected by cnt_sel, combinationally.
- R9: A counter at its maximum (255 for 8 bits) stays at its maximum on further correctable reads.
- R10: cnt_clr high at a clock edge sets the counter selected by cnt_sel to 0, and leaves the other ranks unchanged. The clear wins over an increment of the same rank at the same edge.
- R11: req_ready is low in the cycle after a read is accepted, and stays low until the block returns to the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | 64 | Read data, corrected when possible |
| rsp_ce | output | 1 | Last response was corrected |
| rsp_ue | output | 1 | Last response was uncorrectable |
| ce_pulse | output | 1 | Correctable event pulse |
| ue_pulse | output | 1 | Uncorrectable event pulse |
| err_addr | output | ADDR_W | Address of the latest error event |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 72 | Codeword to store |
| mem_rdata | input | 72 | Codeword read, one cycle after a read enable |
| cnt_sel | input | 2 | Rank selected for counter read or clear |
| cnt_clr | input | 1 | Clear the selected rank counter |
| cnt_value | output | 8 | Counter of the selected rank |

## Verification
The assertions take two things for granted. The memory returns on mem_rdata, exactly one cycle after a read enable, the last codeword written to that address, apart from injected faults. The requester also holds no assumption about ready other than sampling it in the cycle it drives a request. The memory model in the bench honours this fixed one-cycle latency, and faults are flipped into the stored array only between transactions, never during a scrub. The sweeps cover every single-bit position and every two-bit pair of the 72-bit word, so the code is exercised over its full correctable and detectable range.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CW_W   = DATA_W + HAM_W + 1;
    localparam int MAX_POS = DATA_W + HAM_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_DATA = 2'd1,
        ST_SCRUB   = 2'd2
    } ctl_state_t;

    // Hamming check bits: each data bit occupies the next position that is
    // not a power of two; check bit k covers positions with bit k set.
    function automatic logic [HAM_W-1:0] hm_check(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] c;
        int idx;
        c   = '0;
        idx = 0;
        for (int p = 1; p <= MAX_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[idx]) c = c ^ p[HAM_W-1:0];
                idx++;
            end
        end
        return c;
    endfunction

    // Invert the data bit sitting at codeword position pos (no-op for
    // check-bit positions).
    function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                  input logic [HAM_W-1:0]  pos);
        logic [DATA_W-1:0] r;
        int idx;
        r   = d;
        idx = 0;
        for (int p = 1; p <= MAX_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (p == int'(pos)) r[idx] = ~r[idx];
                idx++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    logic [HAM_W-1:0] chk;
    logic             par;

    always_comb begin
        chk  = hm_check(data_i);
        par  = ^{chk, data_i};
        cw_o = {par, chk, data_i};
    end
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
    import ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ce_o,
    output logic              ue_o
);
    logic [HAM_W-1:0] syn;
    logic             par_err;

    always_comb begin
        syn     = hm_check(cw_i[DATA_W-1:0]) ^ cw_i[DATA_W +: HAM_W];
        par_err = ^cw_i;
        data_o  = cw_i[DATA_W-1:0];
        ce_o    = 1'b0;
        ue_o    = 1'b0;
        if (par_err) begin
            if (int'(syn) > MAX_POS) begin
                ue_o = 1'b1;
            end else begin
                ce_o   = 1'b1;
                data_o = flip_at(cw_i[DATA_W-1:0], syn);
            end
        end else if (syn != '0) begin
            ue_o = 1'b1;
        end
    end
endmodule

// File: rtl/ce_counter_bank.sv
module ce_counter_bank #(
    parameter int RANKS = 4,
    parameter int CNT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc,
    input  logic [$clog2(RANKS)-1:0] inc_rank,
    input  logic                     clr,
    input  logic [$clog2(RANKS)-1:0] sel,
    output logic [CNT_W-1:0]         value
);
    localparam int RANK_W = $clog2(RANKS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [RANKS];

    for (genvar g = 0; g < RANKS; g++) begin : g_rank
        logic hit_clr;
        logic hit_inc;
        assign hit_clr = clr && (sel == RANK_W'(g));
        assign hit_inc = inc && (inc_rank == RANK_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (hit_clr) begin
                cnt_q[g] <= '0;
            end else if (hit_inc && cnt_q[g] != CNT_MAX) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end

        p_hold_at_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == CNT_MAX && !hit_clr) |=> (cnt_q[g] == CNT_MAX));

        p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit_clr |=> (cnt_q[g] == '0));
    end

    assign value = cnt_q[sel];
endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int RANKS  = 4,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_ce,
    output logic                     rsp_ue,
    output logic                     ce_pulse,
    output logic                     ue_pulse,
    output logic [ADDR_W-1:0]        err_addr,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [CW_W-1:0]          mem_wdata,
    input  logic [CW_W-1:0]          mem_rdata,
    input  logic [$clog2(RANKS)-1:0] cnt_sel,
    input  logic                     cnt_clr,
    output logic [CNT_W-1:0]         cnt_value
);
    localparam int RANK_W = $clog2(RANKS);

    ctl_state_t state_q, state_d;

    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] fix_data_q;
    logic [DATA_W-1:0] enc_in;
    logic [DATA_W-1:0] dec_data;
    logic              dec_ce;
    logic              dec_ue;
    logic              in_decode;

    ecc_encode u_enc (
        .data_i (enc_in),
        .cw_o   (mem_wdata)
    );

    ecc_decode u_dec (
        .cw_i   (mem_rdata),
        .data_o (dec_data),
        .ce_o   (dec_ce),
        .ue_o   (dec_ue)
    );

    assign in_decode = (state_q == ST_RD_DATA);

    ce_counter_bank #(
        .RANKS (RANKS),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (in_decode && dec_ce),
        .inc_rank (rd_addr_q[ADDR_W-1 -: RANK_W]),
        .clr      (cnt_clr),
        .sel      (cnt_sel),
        .value    (cnt_value)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !req_write) state_d = ST_RD_DATA; // T_ISSUE_READ
            end
            ST_RD_DATA: begin
                if (dec_ce) state_d = ST_SCRUB;                    // T_NEED_SCRUB
                else        state_d = ST_IDLE;                     // T_READ_DONE
            end
            ST_SCRUB: state_d = ST_IDLE;                           // T_SCRUB_DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    // Memory-side and request-side outputs
    always_comb begin
        req_ready = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rd_addr_q;
        enc_in    = fix_data_q;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_en    = req_valid;
                mem_we    = req_write;
                mem_addr  = req_addr;
                enc_in    = req_wdata;
            end
            ST_SCRUB: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            default: ;
        endcase
    end

    // Captured read context and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q  <= '0;
            fix_data_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_ce     <= 1'b0;
            rsp_ue     <= 1'b0;
            ce_pulse   <= 1'b0;
            ue_pulse   <= 1'b0;
            err_addr   <= '0;
        end else begin
            rsp_valid <= in_decode;
            ce_pulse  <= in_decode && dec_ce;
            ue_pulse  <= in_decode && dec_ue;
            if (state_q == ST_IDLE && req_valid && !req_write) begin
                rd_addr_q <= req_addr;
            end
            if (in_decode) begin
                fix_data_q <= dec_data;
                rsp_data   <= dec_data;
                rsp_ce     <= dec_ce;
                rsp_ue     <= dec_ue;
                if (dec_ce || dec_ue) err_addr <= rd_addr_q;
            end
        end
    end

    p_write_even_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (^mem_wdata == 1'b0));

    p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_en && !mem_we, 2));

    p_ce_ue_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse && ue_pulse));

    p_scrub_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |-> (mem_en && mem_we && mem_addr == err_addr && !req_ready));

    p_ce_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |=> !ce_pulse);

    p_ue_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |=> !ue_pulse);

    p_stall_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !req_ready);

endmodule

// File: tb/tb_ecc_scrub_ctrl.sv
module tb_ecc_scrub_ctrl;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_ce, rsp_ue, ce_pulse, ue_pulse;
    logic [7:0]  err_addr;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr;
    logic [71:0] mem_wdata;
    logic [71:0] mem_rdata = '0;
    logic [1:0]  cnt_sel = '0;
    logic        cnt_clr = 1'b0;
    logic [7:0]  cnt_value;

    logic        inj_en = 1'b0;
    logic [7:0]  inj_addr = '0;
    logic [71:0] inj_mask = '0;
    logic [71:0] mem [DEPTH];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int exp_cnt [4];

    // captured by do_read / do_write
    logic        c_valid, c_ce, c_ue, c_pce, c_pue, c_en, c_we, c_ready, c_wait_ready;
    logic [63:0] c_data;
    logic [7:0]  c_eaddr, c_maddr;
    logic [71:0] c_wdata;

    always #2.5 clk = ~clk;

    ecc_scrub_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ce(rsp_ce), .rsp_ue(rsp_ue),
        .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .err_addr(err_addr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cnt_sel(cnt_sel), .cnt_clr(cnt_clr), .cnt_value(cnt_value)
    );

    // Memory model: one-cycle read latency, fault injection by XOR
    always @(posedge clk) begin
        if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [71:0] act, input logic [71:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] pat(input int n);
        return {32'(n) * 32'h9E3779B9, 32'(n + 1) * 32'h85EBCA6B};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [63:0] d, output logic [71:0] cw);
        @(negedge clk);
        chk(req_ready, "R11 ready before write", 72'(req_ready), 72'd1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1;
        cw = mem_wdata;
        chk(mem_en && mem_we && mem_addr == a && mem_wdata[63:0] == d,
            "R1 write drive", {mem_en, mem_we, mem_addr, mem_wdata[61:0]}, {2'b11, a, d[61:0]});
        chk((^mem_wdata) == 1'b0, "R1 even parity", 72'(^mem_wdata), 72'd0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic inject(input logic [7:0] a, input logic [71:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic clr_same);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        c_wait_ready = req_ready;
        if (clr_same) begin
            cnt_clr = 1'b1; cnt_sel = a[7:6];
        end
        @(negedge clk);
        cnt_clr = 1'b0;
        c_valid = rsp_valid; c_data = rsp_data; c_ce = rsp_ce; c_ue = rsp_ue;
        c_pce = ce_pulse; c_pue = ue_pulse; c_eaddr = err_addr;
        c_en = mem_en; c_we = mem_we; c_maddr = mem_addr; c_wdata = mem_wdata;
        c_ready = req_ready;
    endtask

    task automatic check_cnt(input int r, input string tag);
        @(negedge clk);
        cnt_sel = 2'(r);
        #1;
        chk(cnt_value == 8'(exp_cnt[r]), tag, 72'(cnt_value), 72'(exp_cnt[r]));
    endtask

    task automatic bump(input int r);
        if (exp_cnt[r] < 255) exp_cnt[r]++;
    endtask

    initial begin
        logic [71:0] cw;
        logic [7:0]  a;
        for (int r = 0; r < 4; r++) exp_cnt[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !ce_pulse && !ue_pulse, "R2 reset state",
            {68'd0, req_ready, rsp_valid, ce_pulse, ue_pulse}, 72'b1000);
        for (int r = 0; r < 4; r++) check_cnt(r, "R8 counter zero after reset");

        // Clean reads with several patterns
        for (int k = 0; k < 8; k++) begin
            a = 8'(k * 37);
            do_write(a, pat(k * 11), cw);
            do_read(a, 1'b0);
            chk(c_wait_ready == 1'b0, "R11 stall after read", 72'(c_wait_ready), 72'd0);
            chk(c_valid && c_data == pat(k * 11) && !c_ce && !c_ue && !c_pce && !c_pue,
                "R2 clean read", {c_valid, c_ce, c_ue, c_data[63:0]}, {3'b100, pat(k * 11)});
        end
        for (int r = 0; r < 4; r++) check_cnt(r, "R8 clean reads do not count");

        // Every single-bit position
        for (int b = 0; b < 72; b++) begin
            a = {2'(b), 6'(b)};
            do_write(a, pat(b + 100), cw);
            inject(a, 72'(1) << b);
            do_read(a, 1'b0);
            chk(c_valid && c_data == pat(b + 100) && c_ce && !c_ue, "R3 single-bit correction",
                {c_valid, c_ce, c_ue, c_data}, {3'b110, pat(b + 100)});
            chk(c_pce && !c_pue && c_eaddr == a, "R7 correctable pulse and address",
                {62'd0, c_pce, c_pue, c_eaddr}, {62'd0, 2'b10, a});
            chk(c_en && c_we && c_maddr == a && c_wdata == cw && !c_ready, "R5 scrub write-back",
                c_wdata, cw);
            bump(int'(a[7:6]));
            check_cnt(int'(a[7:6]), "R8 counter after correction");
            do_read(a, 1'b0);
            chk(c_valid && !c_ce && !c_ue && c_data == pat(b + 100), "R6 clean after scrub",
                {c_valid, c_ce, c_ue, c_data}, {3'b100, pat(b + 100)});
        end

        // Every two-bit pair
        a = 8'hC5;
        do_write(a, pat(777), cw);
        for (int i = 0; i < 72; i++) begin
            for (int j = i + 1; j < 72; j++) begin
                logic [71:0] m;
                m = (72'(1) << i) | (72'(1) << j);
                inject(a, m);
                do_read(a, 1'b0);
                chk(c_valid && c_ue && !c_ce && c_data == (cw[63:0] ^ m[63:0]),
                    "R4 double-bit detect", {c_valid, c_ce, c_ue, c_data}, {3'b101, cw[63:0] ^ m[63:0]});
                chk(c_pue && !c_pce && c_eaddr == a && !(c_en && c_we), "R7 uncorrectable pulse",
                    {61'd0, c_pue, c_pce, c_en && c_we, c_eaddr}, {61'd0, 3'b100, a});
                inject(a, m);
            end
        end
        check_cnt(3, "R8 uncorrectable reads do not count");

        // Saturation on rank 2
        a = 8'h80;
        do_write(a, pat(4242), cw);
        for (int n = 0; n < 260; n++) begin
            inject(a, 72'(1) << (n % 72));
            do_read(a, 1'b0);
            bump(2);
        end
        check_cnt(2, "R9 counter saturates");
        chk(exp_cnt[2] == 255, "R9 model at max", 72'(exp_cnt[2]), 72'd255);
        inject(a, 72'(1) << 5);
        do_read(a, 1'b0);
        check_cnt(2, "R9 stays at max");

        // Clear: standalone, then against a same-edge increment
        check_cnt(1, "R10 rank 1 before clear");
        @(negedge clk);
        cnt_sel = 2'd2; cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        exp_cnt[2] = 0;
        check_cnt(2, "R10 clear selected rank");
        check_cnt(1, "R10 other rank untouched");
        inject(a, 72'(1) << 40);
        do_read(a, 1'b0);
        bump(2);
        check_cnt(2, "R8 count after clear");
        inject(a, 72'(1) << 7);
        do_read(a, 1'b1);
        chk(c_ce, "R3 correction during clear", 72'(c_ce), 72'd1);
        exp_cnt[2] = 0;
        check_cnt(2, "R10 clear wins over increment");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule